// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block sits between an 8-bit processor's 16-bit address bus and its memories. It drives active-low enables for a ROM, a RAM and a 1 KB memory-mapped I/O window. It also drives the extra high-order address lines that let the processor reach a 64K ROM through a 16K window and a 128K RAM through a 32K window.

A small configuration register controls banking. One bit turns the ROM on or off. A two-bit field picks which 16K ROM bank appears in the top quarter of the address space. Another two-bit field picks which 32K RAM bank appears in the upper half. Writes to the ROM window always go to the RAM underneath, so software can fill shadow RAM without switching the ROM off. When the ROM is off, RAM runs without a gap from the end of the I/O window to the top of memory.

All decode outputs are combinational from the address, the read/write strobe, the clock phase and the register contents. Only the register is clocked.

Top module: `mem_bank_decode`

## Requirements
- R1: `ioCeN` is low exactly when `cpuAddr[15:11]` are all zero and `cpuAddr[10]` is one (addresses 0x0400 to 0x07FF), whatever the register holds.
- R2: Within the I/O window, `ioSelN[k]` is low only for the 256-byte page where `cpuAddr[9:8]` equals k. All bits of `ioSelN` are high outside the window.
- R3: `romCeN` is low exactly when `cpuAddr[15:14]` is 2'b11, the ROM-on bit is 1 and `cpuRnW` is 1.
- R4: Any access that selects neither I/O nor ROM selects RAM. This includes writes to 0xC000 to 0xFFFF and every access while the ROM-on bit is 0. At most one of `romCeN`, `ramCeN` and `ioCeN` is low at any time.
- R5: On a write (`cpuRnW` = 0), `ramCeN` goes low only while `phi2` is 1. On a read, RAM selection does not depend on `phi2`.
- R6: `romHi` equals the ROM bank field when `cpuAddr[15:14]` is 2'b11. Otherwise it is all ones.
- R7: `ramHi` equals the RAM bank field when `cpuAddr[15]` is 1. Otherwise it is all ones.
- R8: On a rising `clk` edge with `cfgWe` high, the register loads `cfgWdata`, and `cfgRdata` always shows the register. The bit layout is:
  - bit 0: ROM-on, where 0 disables the ROM;
  - bits 2:1: ROM bank;
  - bits 4:3: RAM bank.
- R9: While `rstN` is low, the register holds all ones. This turns the ROM on and selects the highest ROM and RAM banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | Processor address bus |
| cpuRnW | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | High phase of the processor clock |
| cfgWe | input | 1 | Configuration register write enable |
| cfgWdata | input | 5 | Configuration write data |
| cfgRdata | output | 5 | Configuration register contents |
| romCeN | output | 1 | ROM chip enable, active low |
| ramCeN | output | 1 | RAM chip enable, active low |
| ioCeN | output | 1 | I/O window enable, active low |
| ioSelN | output | 4 | Per-page I/O device selects, active low |
| romHi | output | 2 | ROM address bits 15:14 |
| ramHi | output | 2 | RAM address bits 16:15 |

## Verification
The bench uses the default build: four I/O pages and two-bit ROM and RAM bank fields, so the register has 32 values. That is small enough to load every register value through the write port. For each value, the bench sweeps the first and last byte of all 256 address pages under both strobe directions and both clock phases. This covers every region boundary, including the edges of the I/O window and the ROM window, and every bank mapping.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int ROM_BANK_W = 2;
  localparam int RAM_BANK_W = 2;
  localparam int CFG_W      = 1 + ROM_BANK_W + RAM_BANK_W;

  // Control-to-datapath strobes; packed so the bit layout is the register layout.
  typedef struct packed {
    logic [RAM_BANK_W-1:0] ramBank;   // bits 4:3
    logic [ROM_BANK_W-1:0] romBank;   // bits 2:1
    logic                  romOn;     // bit 0, low disables ROM
  } cfg_t;
endpackage

// File: rtl/mbd_cfg_ctrl.sv
module mbd_cfg_ctrl
  import mbd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  output cfg_t             cfg
);
  cfg_t cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgQ <= '1;
    else if (cfgWe) cfgQ <= cfg_t'(cfgWdata);
  end

  assign cfg      = cfgQ;
  assign cfgRdata = cfgQ;

  // R8: a write is visible on the readback the next cycle
  a_r8_write_load: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> cfgRdata == $past(cfgWdata));
  // R8: without a write, the register keeps its value
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(cfgRdata));
  // R9: leaving reset, every bit is one
  a_r9_reset_ones: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> cfgRdata == '1);
endmodule

// File: rtl/mbd_addr_path.sv
module mbd_addr_path
  import mbd_pkg::*;
#(
  parameter int IO_PAGES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [15:8]           addrHi,
  input  logic                  cpuRnW,
  input  logic                  phi2,
  input  cfg_t                  cfg,
  output logic                  romCeN,
  output logic                  ramCeN,
  output logic                  ioCeN,
  output logic [IO_PAGES-1:0]   ioSelN,
  output logic [ROM_BANK_W-1:0] romHi,
  output logic [RAM_BANK_W-1:0] ramHi
);
  localparam int PAGE_BITS = (IO_PAGES > 1) ? $clog2(IO_PAGES) : 1;

  logic inIo, inRomWin, romPick, ramPick, ramGate;
  logic [PAGE_BITS-1:0] pageIdx;

  assign inIo     = (addrHi[15:11] == 5'b0) && addrHi[10];
  assign inRomWin = (addrHi[15:14] == 2'b11);
  assign romPick  = inRomWin && cfg.romOn && cpuRnW && !inIo;
  assign ramPick  = !inIo && !romPick;
  assign ramGate  = cpuRnW || phi2;
  assign pageIdx  = addrHi[8 +: PAGE_BITS];

  assign ioCeN  = !inIo;
  assign romCeN = !romPick;
  assign ramCeN = !(ramPick && ramGate);

  for (genvar k = 0; k < IO_PAGES; k++) begin : g_page
    assign ioSelN[k] = !(inIo && (pageIdx == PAGE_BITS'(k)));
  end

  assign romHi = inRomWin  ? cfg.romBank : '1;
  assign ramHi = addrHi[15] ? cfg.ramBank : '1;

  // R1: the I/O window only ever sits in the low 2K
  a_r1_io_region: assert property (@(posedge clk) disable iff (!rstN)
    !ioCeN |-> addrHi[15:11] == 5'b0);
  // R2: a page select only appears inside the window, one at a time
  a_r2_page_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (ioSelN != '1) |-> (!ioCeN && $countones(~ioSelN) == 1));
  // R3: ROM is never enabled on a write
  a_r3_rom_read_only: assert property (@(posedge clk) disable iff (!rstN)
    !romCeN |-> (cpuRnW && romHi == cfg.romBank));
  // R4: at most one device enabled
  a_r4_one_enable: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!romCeN, !ramCeN, !ioCeN}));
  // R5: no RAM write strobe during the low phase
  a_r5_write_phase: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuRnW && !phi2) |-> ramCeN);
  // R7: RAM lower half is always the top bank value
  a_r7_low_half: assert property (@(posedge clk) disable iff (!rstN)
    !addrHi[15] |-> ramHi == '1);
endmodule

// File: rtl/mem_bank_decode.sv
module mem_bank_decode
  import mbd_pkg::*;
#(
  parameter int IO_PAGES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [15:0]           cpuAddr,
  input  logic                  cpuRnW,
  input  logic                  phi2,
  input  logic                  cfgWe,
  input  logic [CFG_W-1:0]      cfgWdata,
  output logic [CFG_W-1:0]      cfgRdata,
  output logic                  romCeN,
  output logic                  ramCeN,
  output logic                  ioCeN,
  output logic [IO_PAGES-1:0]   ioSelN,
  output logic [ROM_BANK_W-1:0] romHi,
  output logic [RAM_BANK_W-1:0] ramHi
);
  cfg_t cfg;
  logic unusedAddrLow;
  assign unusedAddrLow = ^cpuAddr[7:0];

  mbd_cfg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .cfg      (cfg)
  );

  mbd_addr_path #(.IO_PAGES(IO_PAGES)) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .addrHi (cpuAddr[15:8]),
    .cpuRnW (cpuRnW),
    .phi2   (phi2),
    .cfg    (cfg),
    .romCeN (romCeN),
    .ramCeN (ramCeN),
    .ioCeN  (ioCeN),
    .ioSelN (ioSelN),
    .romHi  (romHi),
    .ramHi  (ramHi)
  );
endmodule

// File: tb/mem_bank_decode_test.sv
`timescale 1ns/1ps
module mem_bank_decode_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic cpuRnW = 1'b1;
  logic phi2 = 1'b0;
  logic cfgWe = 1'b0;
  logic [4:0] cfgWdata = '0;
  logic [4:0] cfgRdata;
  logic romCeN, ramCeN, ioCeN;
  logic [3:0] ioSelN;
  logic [1:0] romHi, ramHi;

  int nRun = 0;
  int nFail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  mem_bank_decode uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRnW(cpuRnW), .phi2(phi2),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .romCeN(romCeN), .ramCeN(ramCeN), .ioCeN(ioCeN), .ioSelN(ioSelN),
    .romHi(romHi), .ramHi(ramHi)
  );

  task automatic check(input string req, input int act, input int exp, input int a);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s addr=%h cfg=%h act=%0h exp=%0h", req, a[15:0], cfgRdata, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [4:0] v);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R9: register is all ones in and after reset
    repeat (3) @(negedge clk);
    check("R9", int'(cfgRdata), 31, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", int'(cfgRdata), 31, 0);
    cpuAddr = 16'hC123;
    cpuRnW = 1'b1;
    #1;
    check("R9", int'(romCeN), 0, 16'hC123);
    check("R9", int'(romHi), 3, 16'hC123);
    check("R9", int'(ramHi), 3, 16'hC123);

    for (int c = 0; c < 32; c++) begin
      writeCfg(5'(c));
      #1;
      check("R8", int'(cfgRdata), c, 0);
      for (int pg = 0; pg < 256; pg++) begin
        for (int off = 0; off < 2; off++) begin
          for (int rw = 0; rw < 2; rw++) begin
            for (int ph = 0; ph < 2; ph++) begin
              automatic int a = pg * 256 + off * 255;
              automatic bit expIo = (a >= 16'h0400) && (a < 16'h0800);
              automatic bit romOn = (c & 1) != 0;
              automatic bit expRom = (a >= 16'hC000) && romOn && (rw == 1);
              automatic bit expRam = !expIo && !expRom && (rw == 1 || ph == 1);
              automatic int expSel = expIo ? (15 & ~(1 << ((a >> 8) & 3))) : 15;
              automatic int expRomHi = (a >= 16'hC000) ? ((c >> 1) & 3) : 3;
              automatic int expRamHi = (a >= 16'h8000) ? ((c >> 3) & 3) : 3;
              cpuAddr = 16'(a);
              cpuRnW = rw[0];
              phi2 = ph[0];
              #1;
              check("R1", int'(ioCeN), int'(!expIo), a);
              check("R2", int'(ioSelN), expSel, a);
              check("R3", int'(romCeN), int'(!expRom), a);
              if (rw == 0 && ph == 0)
                check("R5", int'(ramCeN), 1, a);
              else
                check("R4", int'(ramCeN), int'(!expRam), a);
              check("R6", int'(romHi), expRomHi, a);
              check("R7", int'(ramHi), expRamHi, a);
            end
          end
        end
      end
    end

    // R8: a cycle without write enable leaves the register alone
    writeCfg(5'h0A);
    @(negedge clk);
    cfgWdata = 5'h15;
    @(negedge clk);
    check("R8", int'(cfgRdata), 10, 0);

    // R9: reset again brings back all ones
    rstN = 1'b0;
    #1;
    check("R9", int'(cfgRdata), 31, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule